// File: doc/BRIEF.md
# Synchronous Serial Port Controller

This block is the master side of a synchronous serial port, seen by software as a small set of word-addressed registers. Software pushes words into an eight-entry transmit queue by writing the data register. While the port is enabled, a transfer engine takes words from the head of that queue, sends each one out through a word-exchange port and places the word that comes back into an eight-entry receive queue. Software then collects those words by reading the same data register. In loopback mode the exchange port is bypassed, and each transmitted word goes straight into the receive queue.

A control field sets the data width to between 1 and 16 bits. The width masks each word on its way into the transmit queue and again on its way into the receive queue. The engine never overruns the receive queue. When that queue is full the engine waits, and the transmit queue keeps its words until software frees a receive slot. The interrupt line is a level output. It reflects the queue fill levels, filtered through a software mask.

The exchange port uses valid/ready. A request raises `xreq_valid` with the word on `xreq_data` and holds both steady until `xreq_ready` is seen high at a clock edge. The engine then raises `xrsp_ready` and waits for exactly one response beat (`xrsp_valid`). No new request starts before that response has been stored, so the far side may stall either phase for as long as it needs. Register accesses are single-cycle. Read data is combinational during a read cycle, and a read of the data register removes the word at the edge that ends that cycle.

Top module: `ssp_ctrl`

## Requirements
- R1: After reset both queues are empty and the mask register is 0. Status reads 0x03, raw interrupt status reads 0x08, masked status reads 0, and `irq` is low.
- R2: Word address 0 (control 0) reads back all 16 written bits. Word address 1 (control 1) keeps bits [3:0], where bit 0 is loopback, bit 1 is enable, and bits 2 and 3 are stored only. Word address 4 (prescaler) keeps bits [7:0]. Word address 5 (mask) keeps bits [3:0]. Word address 8 always reads 0. Unmapped addresses read 0, and writes to read-only or unmapped addresses change nothing.
- R3: Each queue holds 8 words. A data write (word address 2) to a full transmit queue is dropped. The engine moves no word while the receive queue is full, so the receive queue never exceeds 8 words.
- R4: With control 0 bits [3:0] = N, every word entering the transmit queue is ANDed with 2^(N+1)-1. So is every word stored into the receive queue, including returned exchange words.
- R5: While control 1 bit 1 is 0, the engine starts no transfer and queued words stay where they are.
- R6: With bits 1 and 0 of control 1 both set, one word per cycle moves from the transmit head to the receive tail without any exchange request.
- R7: Without loopback, a request holds `xreq_valid` and `xreq_data` stable until accepted. `xrsp_ready` is high only while one accepted request waits for its response, and `xreq_valid` is never high at the same time.
- R8: Status (word address 3) packs these flags: bit 0 = transmit queue empty, bit 1 = transmit queue not full, bit 2 = receive queue not empty, bit 3 = receive queue full, and bit 4 = busy. Busy is set while the transmit queue holds a word or a transfer is in flight.
- R9: Raw status (word address 6) has bit 3 set when the transmit queue holds 4 words or fewer, and bit 2 set when the receive queue holds 4 words or more. Bits 1 and 0 are always 0. Masked status (word address 7) is raw AND mask, and `irq` is high exactly when that value is nonzero.
- R10: A data read with the receive queue empty returns 0 and leaves both queues unchanged.
- R11: Word addresses 0x3F8 to 0x3FF return, in address order, the bytes 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05 and 0xB1.
- R12: Words come out of the data register in the order they were written or returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 10 | Word address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid during a read cycle |
| xreq_valid | output | 1 | Exchange request valid |
| xreq_ready | input | 1 | Exchange request accepted |
| xreq_data | output | 16 | Word sent out |
| xrsp_valid | input | 1 | Exchange response valid |
| xrsp_ready | output | 1 | Engine waiting for the response |
| xrsp_data | input | 16 | Word returned |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the far side of the exchange port raises `xrsp_valid` only after a request has been accepted, and that register accesses never write control 0 in the same cycle as a data write. The bench builds its responder from a queue that is filled only when a request is accepted, so a response is never offered early. It issues one register access per cycle, which rules out the conflicting writes. It alternates between an always-ready far side and a far side that stalls both phases, so the hold and single-outstanding rules are exercised under back-pressure.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  localparam int ADDR_W = 10;

  localparam logic [ADDR_W-1:0] A_CTL0 = 10'd0;
  localparam logic [ADDR_W-1:0] A_CTL1 = 10'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 10'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 10'd3;
  localparam logic [ADDR_W-1:0] A_PSC  = 10'd4;
  localparam logic [ADDR_W-1:0] A_MASK = 10'd5;
  localparam logic [ADDR_W-1:0] A_RAW  = 10'd6;
  localparam logic [ADDR_W-1:0] A_MIS  = 10'd7;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_REQ,
    ENG_RSP
  } eng_state_e;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    id_byte = 8'h22;
      3'd1:    id_byte = 8'h10;
      3'd2:    id_byte = 8'h04;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    bump = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = mem[rd_ptr];

endmodule

// File: rtl/ssp_engine.sv
module ssp_engine
  import ssp_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          loopback,
  input  logic          tx_avail,
  input  logic          rx_space,
  input  logic [DW-1:0] tx_head,
  output logic          tx_pop,
  output logic          rx_push,
  output logic [DW-1:0] rx_word,
  output logic          in_flight,
  output logic          xreq_valid,
  input  logic          xreq_ready,
  output logic [DW-1:0] xreq_data,
  input  logic          xrsp_valid,
  output logic          xrsp_ready,
  input  logic [DW-1:0] xrsp_data
);

  eng_state_e state_q, state_d;
  logic       can_go;

  assign can_go = enable && tx_avail && rx_space;

  always_comb begin
    state_d = state_q;
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    rx_word = tx_head;
    case (state_q)
      ENG_IDLE: begin
        if (can_go && loopback) begin
          tx_pop  = 1'b1;
          rx_push = 1'b1;
        end else if (can_go) begin
          state_d = ENG_REQ;
        end
      end
      ENG_REQ: begin
        if (xreq_ready) begin
          tx_pop  = 1'b1;
          state_d = ENG_RSP;
        end
      end
      ENG_RSP: begin
        rx_word = xrsp_data;
        if (xrsp_valid) begin
          rx_push = 1'b1;
          state_d = ENG_IDLE;
        end
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ENG_IDLE;
    else        state_q <= state_d;
  end

  assign xreq_valid = (state_q == ENG_REQ);
  assign xreq_data  = tx_head;
  assign xrsp_ready = (state_q == ENG_RSP);
  assign in_flight  = (state_q != ENG_IDLE);

endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int DW         = 16,
  parameter int FIFO_DEPTH = 8,
  localparam int CW   = $clog2(FIFO_DEPTH + 1),
  localparam int HALF = FIFO_DEPTH / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_waddr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              xreq_valid,
  input  logic              xreq_ready,
  output logic [DW-1:0]     xreq_data,
  input  logic              xrsp_valid,
  output logic              xrsp_ready,
  input  logic [DW-1:0]     xrsp_data,
  output logic              irq
);

  logic [15:0]   ctrl0;
  logic [3:0]    ctrl1;
  logic [7:0]    psc;
  logic [3:0]    imsc;
  logic          ctrl_en, ctrl_lb;
  logic [DW-1:0] wmask;

  logic          wr_hit, rd_hit;
  logic          tx_push, tx_pop, rx_push, rx_pop, in_flight;
  logic [DW-1:0] tx_head, rx_head, rx_word;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [4:0]    status;
  logic [3:0]    raw_int;

  assign ctrl_en = ctrl1[1];
  assign ctrl_lb = ctrl1[0];
  assign wmask   = ~({DW{1'b1}} << ({1'b0, ctrl0[3:0]} + 5'd1));

  assign wr_hit = bus_en && bus_we;
  assign rd_hit = bus_en && !bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl0 <= '0;
      ctrl1 <= '0;
      psc   <= '0;
      imsc  <= '0;
    end else if (wr_hit) begin
      case (bus_waddr)
        A_CTL0:  ctrl0 <= bus_wdata;
        A_CTL1:  ctrl1 <= bus_wdata[3:0];
        A_PSC:   psc   <= bus_wdata[7:0];
        A_MASK:  imsc  <= bus_wdata[3:0];
        default: ;
      endcase
    end
  end

  assign tx_full  = (tx_cnt == CW'(FIFO_DEPTH));
  assign tx_empty = (tx_cnt == '0);
  assign rx_full  = (rx_cnt == CW'(FIFO_DEPTH));
  assign rx_empty = (rx_cnt == '0);

  assign tx_push = wr_hit && (bus_waddr == A_DATA) && !tx_full;
  assign rx_pop  = rd_hit && (bus_waddr == A_DATA) && !rx_empty;

  ssp_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (tx_push),
    .push_data (bus_wdata[DW-1:0] & wmask),
    .pop       (tx_pop),
    .head      (tx_head),
    .count     (tx_cnt)
  );

  ssp_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rx_push),
    .push_data (rx_word & wmask),
    .pop       (rx_pop),
    .head      (rx_head),
    .count     (rx_cnt)
  );

  ssp_engine #(.DW(DW)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (ctrl_en),
    .loopback   (ctrl_lb),
    .tx_avail   (!tx_empty),
    .rx_space   (!rx_full),
    .tx_head    (tx_head),
    .tx_pop     (tx_pop),
    .rx_push    (rx_push),
    .rx_word    (rx_word),
    .in_flight  (in_flight),
    .xreq_valid (xreq_valid),
    .xreq_ready (xreq_ready),
    .xreq_data  (xreq_data),
    .xrsp_valid (xrsp_valid),
    .xrsp_ready (xrsp_ready),
    .xrsp_data  (xrsp_data)
  );

  assign status  = {(!tx_empty || in_flight), rx_full, !rx_empty, !tx_full, tx_empty};
  assign raw_int = {(tx_cnt <= CW'(HALF)), (rx_cnt >= CW'(HALF)), 2'b00};
  assign irq     = |(raw_int & imsc);

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      if (bus_waddr[ADDR_W-1:3] == '1) begin
        bus_rdata = {8'h00, id_byte(bus_waddr[2:0])};
      end else begin
        case (bus_waddr)
          A_CTL0:  bus_rdata = ctrl0;
          A_CTL1:  bus_rdata = {12'h000, ctrl1};
          A_DATA:  bus_rdata = rx_empty ? 16'h0000 : 16'(rx_head);
          A_STAT:  bus_rdata = {11'h000, status};
          A_PSC:   bus_rdata = {8'h00, psc};
          A_MASK:  bus_rdata = {12'h000, imsc};
          A_RAW:   bus_rdata = {12'h000, raw_int};
          A_MIS:   bus_rdata = {12'h000, raw_int & imsc};
          default: bus_rdata = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/ssp_ctrl_chk.sv
module ssp_ctrl_chk
  import ssp_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_waddr,
  input logic [15:0]       bus_rdata,
  input logic              irq,
  input logic              xreq_valid,
  input logic              xreq_ready,
  input logic [DW-1:0]     xreq_data,
  input logic              xrsp_ready,
  input logic [CW-1:0]     tx_cnt,
  input logic [CW-1:0]     rx_cnt,
  input logic              tx_pop,
  input logic              rx_push,
  input logic              ctrl_en,
  input logic              ctrl_lb,
  input logic [3:0]        imsc
);

  logic data_wr, data_rd, eng_idle;
  assign data_wr  = bus_en && bus_we && (bus_waddr == A_DATA);
  assign data_rd  = bus_en && !bus_we && (bus_waddr == A_DATA);
  assign eng_idle = !xreq_valid && !xrsp_ready;

  // R3: receive queue is never pushed past its depth
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> (rx_cnt < CW'(DEPTH)));

  // R3: a data write into a full transmit queue leaves it full and unchanged
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && tx_cnt == CW'(DEPTH) && !tx_pop) |=> (tx_cnt == CW'(DEPTH)));

  // R5: no movement and no request while disabled and idle
  p_disabled_still_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && eng_idle) |-> (!tx_pop && !rx_push));

  p_disabled_noreq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && eng_idle) |=> !xreq_valid);

  // R6: loopback from idle never opens an exchange
  p_loop_noreq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_lb && eng_idle) |=> !xreq_valid);

  // R7: request held steady until accepted
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xreq_valid && !xreq_ready) |=> (xreq_valid && $stable(xreq_data)));

  // R7: at most one exchange outstanding
  p_single_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xrsp_ready |-> !xreq_valid);

  // R9: masked-off sources never raise the line
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (imsc == 4'h0) |-> !irq);

  // R10: empty data read returns zero
  p_empty_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && rx_cnt == '0) |-> (bus_rdata == 16'h0000));

endmodule

bind ssp_ctrl ssp_ctrl_chk #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_en     (bus_en),
  .bus_we     (bus_we),
  .bus_waddr  (bus_waddr),
  .bus_rdata  (bus_rdata),
  .irq        (irq),
  .xreq_valid (xreq_valid),
  .xreq_ready (xreq_ready),
  .xreq_data  (xreq_data),
  .xrsp_ready (xrsp_ready),
  .tx_cnt     (tx_cnt),
  .rx_cnt     (rx_cnt),
  .tx_pop     (tx_pop),
  .rx_push    (rx_push),
  .ctrl_en    (ctrl_en),
  .ctrl_lb    (ctrl_lb),
  .imsc       (imsc)
);

// File: tb/sim_ssp_ctrl.sv
module sim_ssp_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [9:0]  bus_waddr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        xreq_valid, xrsp_ready, irq;
  logic        xreq_ready = 1'b0, xrsp_valid = 1'b0;
  logic [15:0] xreq_data;
  logic [15:0] xrsp_data = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ssp_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .xreq_valid(xreq_valid), .xreq_ready(xreq_ready), .xreq_data(xreq_data),
    .xrsp_valid(xrsp_valid), .xrsp_ready(xrsp_ready), .xrsp_data(xrsp_data),
    .irq(irq)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, rmode = 0;
  int txq[$], rxq[$], pend[$];
  int mst = 0;
  int m_ctl0 = 0, m_ctl1 = 0, m_psc = 0, m_mask = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int wmask();
    return (1 << ((m_ctl0 & 15) + 1)) - 1;
  endfunction

  function automatic int raw_exp();
    return ((txq.size() <= 4) ? 8 : 0) | ((rxq.size() >= 4) ? 4 : 0);
  endfunction

  function automatic int stat_exp();
    return int'(txq.size() == 0) | (int'(txq.size() != 8) << 1) |
           (int'(rxq.size() != 0) << 2) | (int'(rxq.size() == 8) << 3) |
           (int'(txq.size() != 0 || mst != 0) << 4);
  endfunction

  function automatic int read_exp(int a);
    int ids[8] = '{8'h22, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (a >= 10'h3F8) return ids[a - 10'h3F8];
    case (a)
      0: return m_ctl0;
      1: return m_ctl1;
      2: return (rxq.size() > 0) ? rxq[0] : 0;
      3: return stat_exp();
      4: return m_psc;
      5: return m_mask;
      6: return raw_exp();
      7: return raw_exp() & m_mask;
      default: return 0;
    endcase
  endfunction

  function automatic int reply(int v);
    return (v * 5 + 16'h03C1) & 16'hFFFF;
  endfunction

  task automatic step(string tag);
    bit en, we, rdy, rv;
    int a, d, rd_data, tsz, rsz, mk, nxt, v;
    cyc++;
    rdy = (rmode == 0) ? 1'b1 : (cyc % 3 == 2);
    rv  = (pend.size() > 0) && (rmode == 0 || cyc % 2 == 1);
    xreq_ready = rdy;
    xrsp_valid = rv;
    xrsp_data  = rv ? 16'(pend[0]) : 16'h0;
    en = bus_en; we = bus_we; a = bus_waddr; d = bus_wdata;
    #1;
    chk("R9 irq", irq, ((raw_exp() & m_mask) != 0));
    chk("R7 xreq_valid", xreq_valid, mst == 1);
    chk("R7 xrsp_ready", xrsp_ready, mst == 2);
    if (mst == 1) chk("R12 xreq_data order", xreq_data, txq[0]);
    if (en && !we) begin
      rd_data = bus_rdata;
      chk(tag, rd_data, read_exp(a));
    end
    @(posedge clk);
    tsz = txq.size(); rsz = rxq.size(); mk = wmask(); nxt = mst;
    if (en && !we && a == 2 && rsz > 0) void'(rxq.pop_front());
    case (mst)
      0: if ((m_ctl1 & 2) && tsz > 0 && rsz < 8) begin
           if (m_ctl1 & 1) begin
             v = txq.pop_front();
             rxq.push_back(v & mk);
           end else nxt = 1;
         end
      1: if (rdy) begin
           v = txq.pop_front();
           pend.push_back(reply(v));
           nxt = 2;
         end
      default: if (rv) begin
           v = pend.pop_front();
           rxq.push_back(v & mk);
           nxt = 0;
         end
    endcase
    mst = nxt;
    if (en && we) begin
      case (a)
        0: m_ctl0 = d & 16'hFFFF;
        1: m_ctl1 = d & 4'hF;
        2: if (tsz < 8) txq.push_back(d & mk);
        4: m_psc = d & 8'hFF;
        5: m_mask = d & 4'hF;
        default: ;
      endcase
    end
    @(negedge clk);
    bus_en = 1'b0;
    bus_we = 1'b0;
  endtask

  task automatic wr(int a, int d);
    bus_en = 1'b1; bus_we = 1'b1; bus_waddr = 10'(a); bus_wdata = 16'(d);
    step("wr");
  endtask

  task automatic rd(int a, string tag);
    bus_en = 1'b1; bus_we = 1'b0; bus_waddr = 10'(a);
    step(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step("idle");
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    rd(3, "R1 status"); rd(6, "R1 raw"); rd(5, "R1 mask"); rd(7, "R1 masked");
    // R2: register storage and ignored writes
    wr(0, 16'hABC7); rd(0, "R2 ctl0");
    wr(4, 16'h01FF); rd(4, "R2 prescaler");
    wr(8, 5); rd(8, "R2 dma zero");
    wr(3, 16'hFFFF); wr(6, 16'hFFFF); rd(3, "R2 status ro"); rd(6, "R2 raw ro");
    rd(10'h040, "R2 unmapped");
    wr(1, 16'hFFFC); rd(1, "R2 ctl1");
    // R5: disabled, words stay queued
    wr(1, 0); wr(0, 7);
    wr(2, 16'h1A5); wr(2, 16'h033); wr(2, 16'h2FF);
    idle(5); rd(3, "R5 status held"); rd(6, "R5 raw");
    rd(2, "R10 empty read"); rd(3, "R10 status unchanged");
    // R6: loopback drains one per cycle, R4 mask 8 bits
    wr(1, 3); idle(3);
    rd(3, "R6 status"); rd(2, "R6 data0"); rd(2, "R4 data1"); rd(2, "R12 data2");
    // R3: fill beyond depth while disabled
    wr(1, 1); wr(0, 4);
    for (int i = 0; i < 10; i++) wr(2, 16'h0FE0 + i * 7);
    rd(3, "R3 tx full status");
    wr(5, 4'hC); rd(6, "R9 raw full"); rd(7, "R9 masked");
    wr(1, 3); idle(4);
    for (int i = 0; i < 3; i++) wr(2, 16'h0055 + i);
    idle(4); rd(3, "R3 rx full stall"); rd(7, "R9 masked stall");
    for (int i = 0; i < 13; i++) rd(2, "R12 drain");
    rd(2, "R10 empty again"); rd(3, "R3 final status");
    // R7: exchange with always-ready far side, 16-bit words
    wr(1, 2); wr(0, 15);
    for (int i = 0; i < 6; i++) wr(2, 16'hF00D + i * 16'h111);
    idle(10);
    for (int i = 0; i < 6; i++) rd(2, "R7 returned");
    // R7: stalling far side, R4 5-bit mask on returned words
    rmode = 1; wr(0, 4);
    for (int i = 0; i < 9; i++) wr(2, 16'h0123 * (i + 1));
    rd(3, "R8 busy");
    wr(1, 0); idle(6); wr(1, 2);
    idle(60); rd(3, "R8 status after");
    for (int i = 0; i < 9; i++) rd(2, "R4 returned masked");
    rmode = 0; wr(5, 0);
    // R11: identification bytes
    for (int i = 0; i < 8; i++) rd(10'h3F8 + i, "R11 id");
    rd(3, "R8 idle status");
    summary();
    $finish;
  end

endmodule